// File: doc/BRIEF.md
# Parallel Peripheral Bus Cycle Master

This block turns single-word requests from on-chip logic into 8080-style asynchronous read and write cycles on an external parallel bus. The bus is shared by four serial-port channels. They have a common 8-bit data bus, a common 3-bit register address and common active-low read and write strobes. Each channel has its own active-low chip select. A request names the direction, the channel, the register address and, for a write, the data byte. The block drives the address before the chip select falls, and for a write it also drives the data and turns on the data driver first. It then steps through a fixed sequence of strobe edges with a programmable wait between each pair of edges.

A read samples the incoming data bus partway through the read-strobe pulse and holds the byte on `rdata`. When a cycle ends the block raises `done` for one clock. If the channel index is out of range, the request is refused without touching the bus, and `err` is raised together with `done`.

Top module: `pbus_cycle_master`

## Requirements
- R1: After reset every chip select and both strobes are high, `bus_oe` is 0, `busy`, `done` and `err` are 0, and `rdata` is 0.
- R2: A write accepted at clock edge E0 drives `bus_addr`, `bus_dout` and `bus_oe`=1 at E0. The chip select falls at E0+1 and `wr_n` falls WAIT_CYC edges later. `wr_n` rises after another WAIT_CYC edges, and the chip select rises after another WAIT_CYC edges.
- R3: A read accepted at E0 leaves `bus_oe` at 0 and sets the address at E0. The chip select falls at E0+1 and `rd_n` falls WAIT_CYC edges later. `rd_n` rises 2*WAIT_CYC edges after it fell, and the chip select rises WAIT_CYC edges after that.
- R4: A read captures `bus_din` at the edge WAIT_CYC cycles after `rd_n` fell. `rdata` keeps the captured byte until the next read captures a new one.
- R5: Channel index k drives only `cs_n[k]` low. At most one chip select is low at any time.
- R6: `busy` is high from the edge after acceptance until the edge one cycle after the chip select rises. At that edge `busy` falls and `done` is high for exactly one cycle.
- R7: A request presented while `busy` is high is ignored. The address, data and selected channel of the cycle in progress do not change.
- R8: An index of NUM_CHAN or more is rejected. No chip select or strobe moves, `busy` stays 0, and `done` and `err` are both high for one cycle at the edge after the request.
- R9: After a write, `bus_oe` falls at the same edge as `done` rises.
- R10: The spacing between consecutive strobe or select edges is WAIT_CYC clock cycles (default 3).
- R11: If a request is held at the port through the cycle in which `done` is high, it is accepted again at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_chan | input | IDX_W | Channel index |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Rejected request, valid with done |
| rdata | output | DATA_W | Last byte read |
| bus_addr | output | ADDR_W | External register address |
| bus_dout | output | DATA_W | Data driven toward the bus |
| bus_oe | output | 1 | Data driver enable |
| bus_din | input | DATA_W | Data returned by the bus |
| cs_n | output | NUM_CHAN | Active-low chip selects |
| wr_n | output | 1 | Active-low write strobe |
| rd_n | output | 1 | Active-low read strobe |

## Verification
Two situations are hard to reach from the ports. The first is the moment a cycle ends: a request held at the input across the single `done` clock must be taken again at once. The second is a request arriving in the middle of a cycle, which must change nothing. The stimulus covers both. It keeps `req_valid` high through a whole transfer, and it injects a conflicting request while a read strobe is low. To prove that a read samples at exactly one edge, `bus_din` changes on every clock. Any shift in the sampling instant then yields a different byte in `rdata`.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SETUP,
      ST_RUN,
      ST_END
   } pbm_state_e;
endpackage

// File: rtl/pbm_wait_timer.sv
module pbm_wait_timer #(
   parameter int WAIT_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WAIT_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= RELOAD;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/pbm_chan_decode.sv
module pbm_chan_decode #(
   parameter int NUM_CHAN = 4,
   parameter int IDX_W    = 3
) (
   input  logic [IDX_W-1:0]    idx,
   output logic [NUM_CHAN-1:0] onehot,
   output logic                in_range
);
   for (genvar k = 0; k < NUM_CHAN; k++) begin : g_sel
      assign onehot[k] = (idx == IDX_W'(k));
   end
   assign in_range = |onehot;
endmodule

// File: rtl/pbus_cycle_master.sv
module pbus_cycle_master
   import pbm_pkg::*;
#(
   parameter int NUM_CHAN = 4,
   parameter int IDX_W    = 3,
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 8,
   parameter int WAIT_CYC = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [IDX_W-1:0]    req_chan,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                busy,
   output logic                done,
   output logic                err,
   output logic [DATA_W-1:0]   rdata,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic [DATA_W-1:0]   bus_dout,
   output logic                bus_oe,
   input  logic [DATA_W-1:0]   bus_din,
   output logic [NUM_CHAN-1:0] cs_n,
   output logic                wr_n,
   output logic                rd_n
);
   // phase numbering: 1 select on, 2 strobe on, then per direction
   localparam logic [2:0] PH_WR_LAST = 3'd3;
   localparam logic [2:0] PH_RD_LAST = 3'd4;

   if (WAIT_CYC < 1) begin : g_bad_wait
      $error("WAIT_CYC must be at least 1");
   end
   if ((1 << IDX_W) < NUM_CHAN) begin : g_bad_idx
      $error("IDX_W too narrow for NUM_CHAN");
   end

   pbm_state_e          state_q;
   logic [2:0]          ph_q;
   logic                is_wr_q;
   logic                cs_act_q;
   logic [NUM_CHAN-1:0] sel_q;
   logic [NUM_CHAN-1:0] dec_onehot;
   logic                dec_ok;
   logic                tmr_load;
   logic                tmr_zero;
   logic                step;

   pbm_chan_decode #(.NUM_CHAN(NUM_CHAN), .IDX_W(IDX_W)) u_dec (
      .idx      (req_chan),
      .onehot   (dec_onehot),
      .in_range (dec_ok)
   );

   assign step     = (state_q == ST_RUN) && tmr_zero;
   assign tmr_load = (state_q == ST_SETUP) || step;

   pbm_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .expired (tmr_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         ph_q     <= '0;
         is_wr_q  <= 1'b0;
         cs_act_q <= 1'b0;
         sel_q    <= '0;
         wr_n     <= 1'b1;
         rd_n     <= 1'b1;
         bus_oe   <= 1'b0;
         busy     <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
         bus_addr <= '0;
         bus_dout <= '0;
         rdata    <= '0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (dec_ok) begin
                     sel_q    <= dec_onehot;
                     bus_addr <= req_addr;
                     bus_dout <= req_wdata;
                     bus_oe   <= req_write;
                     is_wr_q  <= req_write;
                     busy     <= 1'b1;
                     state_q  <= ST_SETUP;
                  end else begin
                     done <= 1'b1;
                     err  <= 1'b1;
                  end
               end
            end
            ST_SETUP: begin
               cs_act_q <= 1'b1;
               ph_q     <= 3'd1;
               state_q  <= ST_RUN;
            end
            ST_RUN: begin
               if (step) begin
                  ph_q <= ph_q + 3'd1;
                  if (is_wr_q) begin
                     case (ph_q)
                        3'd1:    wr_n <= 1'b0;
                        3'd2:    wr_n <= 1'b1;
                        default: ;
                     endcase
                     if (ph_q == PH_WR_LAST) begin
                        cs_act_q <= 1'b0;
                        state_q  <= ST_END;
                     end
                  end else begin
                     case (ph_q)
                        3'd1:    rd_n  <= 1'b0;
                        3'd2:    rdata <= bus_din;
                        3'd3:    rd_n  <= 1'b1;
                        default: ;
                     endcase
                     if (ph_q == PH_RD_LAST) begin
                        cs_act_q <= 1'b0;
                        state_q  <= ST_END;
                     end
                  end
               end
            end
            ST_END: begin
               busy    <= 1'b0;
               done    <= 1'b1;
               bus_oe  <= 1'b0;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cs_n = ~(sel_q & {NUM_CHAN{cs_act_q}});
endmodule

// File: rtl/pbm_checker.sv
module pbm_checker #(
   parameter int NUM_CHAN = 4,
   parameter int ADDR_W   = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_CHAN-1:0] cs_n,
   input logic                wr_n,
   input logic                rd_n,
   input logic                bus_oe,
   input logic                busy,
   input logic                done,
   input logic                err,
   input logic [ADDR_W-1:0]   bus_addr
);
   // R5
   single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R2
   wr_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> !(&cs_n));

   // R9
   wr_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> bus_oe);

   // R3
   rd_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (!bus_oe && !(&cs_n)));

   // R3
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   // R6
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done && &cs_n));

   // R8
   reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && !busy && &cs_n && wr_n && rd_n));

   // R7
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(bus_addr));
endmodule

bind pbus_cycle_master pbm_checker #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (cs_n),
   .wr_n     (wr_n),
   .rd_n     (rd_n),
   .bus_oe   (bus_oe),
   .busy     (busy),
   .done     (done),
   .err      (err),
   .bus_addr (bus_addr)
);

// File: tb/pbus_cycle_master_tb.sv
`timescale 1ns/1ps
module pbus_cycle_master_tb;
   localparam int NCH = 4;
   localparam int IW  = 3;
   localparam int AW  = 3;
   localparam int DW  = 8;
   localparam int W   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_write = 1'b0;
   logic [IW-1:0] req_chan = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic busy, done, err, bus_oe, wr_n, rd_n;
   logic [DW-1:0] rdata, bus_dout;
   logic [DW-1:0] bus_din = '0;
   logic [AW-1:0] bus_addr;
   logic [NCH-1:0] cs_n;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   pbus_cycle_master #(.NUM_CHAN(NCH), .IDX_W(IW), .ADDR_W(AW), .DATA_W(DW), .WAIT_CYC(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_chan(req_chan), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .done(done), .err(err), .rdata(rdata),
      .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din),
      .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // behavioural reference: t counts edges since acceptance, -1 when idle
   int t = -1;
   bit m_wr;
   int m_ch;
   logic [NCH-1:0] e_cs_n = '1;
   logic e_wr_n = 1, e_rd_n = 1, e_oe = 0, e_busy = 0, e_done = 0, e_err = 0;
   logic [DW-1:0] e_rdata = '0, e_dout = '0;
   logic [AW-1:0] e_addr = '0;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         t = -1; e_cs_n = '1; e_wr_n = 1; e_rd_n = 1; e_oe = 0;
         e_busy = 0; e_done = 0; e_err = 0; e_rdata = '0; e_dout = '0; e_addr = '0;
      end else if (t < 0) begin
         e_done = 0; e_err = 0;
         if (req_valid) begin
            if (int'(req_chan) >= NCH) begin
               e_done = 1; e_err = 1;
            end else begin
               t = 0; m_wr = req_write; m_ch = int'(req_chan);
               e_addr = req_addr; e_dout = req_wdata; e_oe = req_write; e_busy = 1;
            end
         end
      end else begin
         int last_edge;
         t++;
         last_edge = m_wr ? 1 + 3*W : 1 + 4*W;
         e_cs_n = (t >= 1 && t < last_edge) ? ~(NCH'(1) << m_ch) : '1;
         e_wr_n = !(m_wr && t >= 1 + W && t < 1 + 2*W);
         e_rd_n = !(!m_wr && t >= 1 + W && t < 1 + 3*W);
         if (!m_wr && t == 1 + 2*W) e_rdata = bus_din;
         if (t == last_edge + 1) begin
            e_busy = 0; e_done = 1; e_oe = 0; t = -1;
         end
      end
   end

   always @(negedge clk) begin
      bus_din <= 8'(cyc * 29 + 7);
      if (cyc >= 1) begin
         chk("R5 cs_n", 32'(cs_n), 32'(e_cs_n));
         chk("R2/R10 wr_n", 32'(wr_n), 32'(e_wr_n));
         chk("R3/R10 rd_n", 32'(rd_n), 32'(e_rd_n));
         chk("R9 bus_oe", 32'(bus_oe), 32'(e_oe));
         chk("R6 busy", 32'(busy), 32'(e_busy));
         chk("R6 done", 32'(done), 32'(e_done));
         chk("R8 err", 32'(err), 32'(e_err));
         chk("R4 rdata", 32'(rdata), 32'(e_rdata));
         chk("R2 bus_addr", 32'(bus_addr), 32'(e_addr));
         chk("R2 bus_dout", 32'(bus_dout), 32'(e_dout));
      end
   end

   task automatic issue(bit wr, int ch, int a, int d);
      @(negedge clk);
      req_valid = 1; req_write = wr; req_chan = IW'(ch); req_addr = AW'(a); req_wdata = DW'(d);
      @(negedge clk);
      req_valid = 0;
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      chk("R1 cs_n", 32'(cs_n), 32'hF);
      chk("R1 strobes", {30'd0, wr_n, rd_n}, 32'h3);
      chk("R1 flags", {28'd0, bus_oe, busy, done, err}, 32'h0);
      chk("R1 rdata", 32'(rdata), 32'h0);
      rst_n = 1;
      issue(1, 0, 3, 8'hA5);
      issue(0, 1, 5, 0);
      issue(1, 2, 7, 8'h3C);
      issue(0, 3, 0, 0);
      // R8 out-of-range channels
      issue(1, 4, 1, 8'hFF);
      issue(0, 7, 2, 0);
      chk("R8 no select after reject", 32'(cs_n), 32'hF);
      // R7 conflicting request mid-cycle
      @(negedge clk);
      req_valid = 1; req_write = 0; req_chan = 2; req_addr = 6;
      @(negedge clk);
      req_valid = 0;
      repeat (6) @(negedge clk);
      req_valid = 1; req_write = 1; req_chan = 0; req_addr = 1; req_wdata = 8'h11;
      @(negedge clk);
      req_valid = 0;
      chk("R7 addr held", 32'(bus_addr), 32'h6);
      while (!done) @(negedge clk);
      @(negedge clk);
      // R11 held request re-accepted right after done
      req_valid = 1; req_write = 1; req_chan = 1; req_addr = 4; req_wdata = 8'h5A;
      while (!done) @(negedge clk);
      @(negedge clk);
      chk("R11 busy again after done", 32'(busy), 32'h1);
      req_valid = 0;
      while (!done) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule